// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block sends one character at a time on a single serial line. A six-bit mode word picks between asynchronous framing and a clocked synchronous format. Asynchronous framing is a start bit, 7 or 8 data bits sent least significant bit first, an optional even or odd parity bit, and one or two stop bits. The synchronous format is a fixed 8-bit shift with a companion clock output. A byte is offered on a valid/ready handshake. The block copies the mode word at the moment it accepts the byte and uses that copy until the frame is done. Bit timing comes from a one-cycle `bit_tick` pulse that an external rate generator supplies.

The controller is a single state machine with these states: IDLE, ALIGN, START, DATA, PARITY, STOP1, STOP2, SYNC_LO and SYNC_HI. Its transitions are:

- IDLE→ALIGN when a byte is accepted.
- ALIGN→START on a tick in asynchronous mode, and ALIGN→SYNC_LO on a tick in synchronous mode.
- START→DATA on a tick.
- DATA→DATA on a tick when bits remain. On a tick after the last data bit, DATA→PARITY if parity is sent, otherwise DATA→STOP1.
- PARITY→STOP1 on a tick.
- STOP1→STOP2 on a tick when two stop bits are selected, otherwise STOP1→IDLE.
- STOP2→IDLE on a tick.
- SYNC_LO→SYNC_HI on a tick.
- SYNC_HI→SYNC_LO on a tick when bits remain, otherwise SYNC_HI→IDLE.

In every other cycle the state holds. A data shifter holds the byte and counts the bits sent. A configuration decoder turns the mode word into a bit count, a parity decision and a parity value.

Top module: `sftx_top`

## Requirements
- R1: After reset, `ser_out` = 1, `ser_clk` = 1, `busy` = 0 and `tx_ready` = 1.
- R2: A byte is taken in a cycle where `tx_valid` and `tx_ready` are both 1. From the next cycle, `tx_ready` = 0 and `busy` = 1. `tx_ready` returns to 1 in the cycle after the tick that ends the final bit.
- R3: The first bit appears in the cycle after the first tick that follows acceptance. Every change of `ser_out`/`ser_clk` takes place in the cycle after a tick, and the outputs hold steady between ticks.
- R4: In asynchronous mode (mode_word[0] = 0) a frame is a 0 start bit, then the data bits LSB first, then stop bits at 1. The line rests at 1 when idle.
- R5: mode_word[1] = 0 sends 8 data bits. mode_word[1] = 1 sends 7, and bit 7 of the byte is never driven onto the line.
- R6: mode_word[2] = 1 adds a parity bit after the data. With mode_word[3] = 0 the data bits plus the parity bit hold an even number of ones; with mode_word[3] = 1 they hold an odd number.
- R7: mode_word[5] = 1 suppresses the parity bit whatever mode_word[2] says.
- R8: mode_word[4] = 0 sends one stop bit and mode_word[4] = 1 sends two.
- R9: With mode_word[0] = 1 the frame is exactly 8 data bits, LSB first, with no start, parity or stop bit. mode_word[1], [2], [3] and [4] have no effect.
- R10: In synchronous mode `ser_clk` rests at 1. It falls on the tick where each data bit is placed on `ser_out` and rises on the following tick, so each bit spans two ticks. In asynchronous mode `ser_clk` stays at 1.
- R11: Changing `mode_word` while a frame is running does not alter that frame.
- R12: `tx_valid` and `tx_data` are ignored while `busy` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block can take a byte |
| mode_word | input | 6 | [0] sync, [1] short char, [2] parity on, [3] odd parity, [4] two stops, [5] multiprocessor format |
| bit_tick | input | 1 | One-cycle bit-rate pulse |
| ser_out | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock for synchronous mode |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters, DATA_W = 8 and SHORT_W = 7. With these values the short-character mode drops exactly the top bit, so a byte with bit 7 set shows whether that bit leaks onto the line. Ticks arrive every three clocks, which leaves a quiet cycle between ticks to check that the outputs hold. A full synchronous frame and the longest asynchronous frame, at twelve bits, both fit in a short run. Mode words disturbed in the middle of a frame, and bytes offered while busy, test the sampling rule and the handshake.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    localparam int MODE_W = 6;

    // bit 0 is the least significant field of the packed struct
    typedef struct packed {
        logic mp_fmt;
        logic two_stop;
        logic par_odd;
        logic par_en;
        logic len7;
        logic sync;
    } sftx_mode_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2,
        ST_SYNC_LO,
        ST_SYNC_HI
    } sftx_state_e;

endpackage

// File: rtl/sftx_frame_cfg.sv
module sftx_frame_cfg
    import sftx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SHORT_W = 7,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  sftx_mode_t         mode,
    input  logic [DATA_W-1:0]  data,
    output logic [CNT_W-1:0]   nbits,
    output logic               send_par,
    output logic               par_bit,
    output logic               two_stop
);

    localparam logic [DATA_W-1:0] FULL_MASK  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] SHORT_MASK = {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    logic short_char;
    logic [DATA_W-1:0] mask;

    always_comb begin
        short_char = mode.len7 && !mode.sync;
        mask       = short_char ? SHORT_MASK : FULL_MASK;
        nbits      = short_char ? CNT_W'(SHORT_W) : CNT_W'(DATA_W);
        // the multiprocessor flag overrides the parity enable
        send_par   = !mode.sync && mode.par_en && !mode.mp_fmt;
        par_bit    = (^(data & mask)) ^ mode.par_odd;
        two_stop   = !mode.sync && mode.two_stop;
    end

endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DATA_W-1:0]  load_data,
    input  logic [CNT_W-1:0]   load_nbits,
    input  logic               shift,
    output logic               cur_bit,
    output logic               last
);

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  nb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
            nb_q  <= '0;
        end else if (load) begin
            sh_q  <= load_data;
            cnt_q <= '0;
            nb_q  <= load_nbits;
        end else if (shift) begin
            sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        cur_bit = sh_q[0];
        last    = (cnt_q == nb_q - CNT_W'(1));
    end

    // bit counter never runs past the loaded length (R5)
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_q != '0) |-> (cnt_q < nb_q));

endmodule

// File: rtl/sftx_top.sv
module sftx_top
    import sftx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SHORT_W = 7,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    input  logic [MODE_W-1:0]  mode_word,
    input  logic               bit_tick,
    output logic               ser_out,
    output logic               ser_clk,
    output logic               busy
);

    sftx_state_e state_q, state_d;
    sftx_mode_t  mode_in, mode_q;

    logic [CNT_W-1:0] cfg_nbits;
    logic cfg_send_par, cfg_par_bit, cfg_two_stop;
    logic send_par_q, par_bit_q, two_stop_q;
    logic accept, shift, cur_bit, last;

    assign mode_in = sftx_mode_t'(mode_word);
    assign accept  = tx_valid && (state_q == ST_IDLE);

    sftx_frame_cfg #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) i_cfg (
        .mode     (mode_in),
        .data     (tx_data),
        .nbits    (cfg_nbits),
        .send_par (cfg_send_par),
        .par_bit  (cfg_par_bit),
        .two_stop (cfg_two_stop)
    );

    sftx_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_data  (tx_data),
        .load_nbits (cfg_nbits),
        .shift      (shift),
        .cur_bit    (cur_bit),
        .last       (last)
    );

    // frame settings captured once per accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            send_par_q <= 1'b0;
            par_bit_q  <= 1'b0;
            two_stop_q <= 1'b0;
        end else if (accept) begin
            mode_q     <= mode_in;
            send_par_q <= cfg_send_par;
            par_bit_q  <= cfg_par_bit;
            two_stop_q <= cfg_two_stop;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept)   state_d = ST_ALIGN;
            ST_ALIGN:   if (bit_tick) state_d = mode_q.sync ? ST_SYNC_LO : ST_START;
            ST_START:   if (bit_tick) state_d = ST_DATA;
            ST_DATA:    if (bit_tick && last)
                            state_d = send_par_q ? ST_PARITY : ST_STOP1;
            ST_PARITY:  if (bit_tick) state_d = ST_STOP1;
            ST_STOP1:   if (bit_tick) state_d = two_stop_q ? ST_STOP2 : ST_IDLE;
            ST_STOP2:   if (bit_tick) state_d = ST_IDLE;
            ST_SYNC_LO: if (bit_tick) state_d = ST_SYNC_HI;
            ST_SYNC_HI: if (bit_tick) state_d = last ? ST_IDLE : ST_SYNC_LO;
            default:                  state_d = ST_IDLE;
        endcase
    end

    assign shift = bit_tick && !last &&
                   ((state_q == ST_DATA) || (state_q == ST_SYNC_HI));

    // outputs
    always_comb begin
        ser_out  = 1'b1;
        ser_clk  = 1'b1;
        tx_ready = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE:    begin tx_ready = 1'b1; busy = 1'b0; end
            ST_ALIGN:   ser_out = 1'b1;
            ST_START:   ser_out = 1'b0;
            ST_DATA:    ser_out = cur_bit;
            ST_PARITY:  ser_out = par_bit_q;
            ST_STOP1:   ser_out = 1'b1;
            ST_STOP2:   ser_out = 1'b1;
            ST_SYNC_LO: begin ser_out = cur_bit; ser_clk = 1'b0; end
            ST_SYNC_HI: ser_out = cur_bit;
            default:    ser_out = 1'b1;
        endcase
    end

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && busy));

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> ($stable(ser_out) && $stable(ser_clk)));

    assert_parity_only_async_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARITY) |-> (!mode_q.sync && mode_q.par_en && !mode_q.mp_fmt));

    assert_second_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP2) |-> (mode_q.two_stop && !mode_q.sync));

    assert_sclk_sync_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_clk |-> mode_q.sync);

    assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(mode_q)));

endmodule

// File: tb/test_sftx_top.sv
`timescale 1ns/1ps
module test_sftx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [5:0] mode_word = '0;
    logic       bit_tick = 1'b0;
    logic       ser_out, ser_clk, busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    sftx_top i_sftx_top (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .mode_word(mode_word), .bit_tick(bit_tick),
        .ser_out(ser_out), .ser_clk(ser_clk), .busy(busy)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    // sends one byte, checks every bit position and the handshake
    task automatic run_frame(input logic [7:0] d, input logic [5:0] m,
                             input logic disturb, input string req);
        logic eo [0:31];
        logic ec [0:31];
        int   n = 0;
        int   nb;
        logic par;
        if (m[0]) begin
            for (int i = 0; i < 8; i++) begin
                eo[n] = d[i]; ec[n] = 1'b0; n++;
                eo[n] = d[i]; ec[n] = 1'b1; n++;
            end
        end else begin
            nb = m[1] ? 7 : 8;
            eo[n] = 1'b0; ec[n] = 1'b1; n++;
            par = m[3];
            for (int i = 0; i < nb; i++) begin
                eo[n] = d[i]; ec[n] = 1'b1; n++;
                par = par ^ d[i];
            end
            if (m[2] && !m[5]) begin eo[n] = par; ec[n] = 1'b1; n++; end
            eo[n] = 1'b1; ec[n] = 1'b1; n++;
            if (m[4]) begin eo[n] = 1'b1; ec[n] = 1'b1; n++; end
        end
        @(negedge clk);
        tx_data = d; mode_word = m; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0 && busy == 1'b1, "R2 accept", int'(tx_ready), 0);
        chk(ser_out == 1'b1 && ser_clk == 1'b1, "R3 wait for tick", int'(ser_out), 1);
        if (disturb) begin
            mode_word = ~m; tx_data = ~d; tx_valid = 1'b1;
        end
        for (int k = 0; k < n; k++) begin
            tick_once();
            chk(ser_out == eo[k], req, int'(ser_out), int'(eo[k]));
            chk(ser_clk == ec[k], "R10 ser_clk", int'(ser_clk), int'(ec[k]));
            chk(tx_ready == 1'b0, "R2 ready low in frame", int'(tx_ready), 0);
            if (k == 1) tx_valid = 1'b0;
            @(negedge clk);
            chk(ser_out == eo[k], "R3 hold between ticks", int'(ser_out), int'(eo[k]));
        end
        tick_once();
        chk(tx_ready == 1'b1 && busy == 1'b0, "R2 ready after last bit", int'(tx_ready), 1);
        chk(ser_out == 1'b1 && ser_clk == 1'b1, "R4 idle line", int'(ser_out), 1);
        mode_word = m;
    endtask

    task automatic test_reset();
        chk(ser_out == 1'b1, "R1 ser_out", int'(ser_out), 1);
        chk(ser_clk == 1'b1, "R1 ser_clk", int'(ser_clk), 1);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    endtask

    task automatic test_async_basic();
        run_frame(8'hA5, 6'b000000, 1'b0, "R4 8N1 frame");
        run_frame(8'h3C, 6'b000000, 1'b0, "R4 8N1 frame");
    endtask

    task automatic test_short_char();
        run_frame(8'hFF, 6'b000010, 1'b0, "R5 7-bit drops bit 7");
        run_frame(8'h80, 6'b000010, 1'b0, "R5 7-bit drops bit 7");
    endtask

    task automatic test_parity();
        run_frame(8'h07, 6'b000100, 1'b0, "R6 even parity");
        run_frame(8'h07, 6'b001100, 1'b0, "R6 odd parity");
        run_frame(8'hC1, 6'b001110, 1'b0, "R6 odd parity 7-bit");
    endtask

    task automatic test_mp_format();
        run_frame(8'h55, 6'b100100, 1'b0, "R7 mp suppresses parity");
    endtask

    task automatic test_two_stop();
        run_frame(8'h12, 6'b010000, 1'b0, "R8 two stops");
        run_frame(8'h9E, 6'b011100, 1'b0, "R8 two stops with parity");
    endtask

    task automatic test_sync();
        run_frame(8'h6B, 6'b000001, 1'b0, "R9 sync frame");
        run_frame(8'hD2, 6'b011111, 1'b0, "R9 sync ignores fields");
    endtask

    task automatic test_mode_frozen();
        run_frame(8'h4D, 6'b000100, 1'b1, "R11 R12 disturbed async");
        run_frame(8'hB3, 6'b000001, 1'b1, "R11 R12 disturbed sync");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_async_basic();
        test_short_char();
        test_parity();
        test_mp_format();
        test_two_stop();
        test_sync();
        test_mode_frozen();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule